// File: doc/BRIEF.md
# Camera Capture Window Cropper

This block sits behind a parallel camera port. The camera drives a pixel clock, a data byte per clock, and two sync lines. Horizontal sync and vertical sync are both active high, and a sample counts as pixel data only while both are low. The block counts pixels within a line and lines within a frame. It forwards only the bytes that fall inside a rectangle, which is set by four inputs: a pixel offset and a pixel count that fix the horizontal span, and a first line and a line count that fix the vertical span.

Capture is frame-based. Once `enable` is high, the block waits for the next falling edge of vertical sync. At that edge it latches the window settings and begins counting. It stops when the last window line closes, or earlier if vertical sync rises before that line is reached. In both cases it emits a one-cycle `frame_done` pulse, and also a `frame_irq` pulse when `irq_en` is set. It then waits for the next frame start. Forwarded bytes come out registered, with a valid strobe.

Top module: `cam_window_crop`

## Requirements
- R1: A sample is treated as pixel data only when `hsync` and `vsync` are both low on that clock edge. No sample taken while either sync is high is ever forwarded.
- R2: Pixel positions restart at 0 after every high period of `hsync`. Within a window line, the pixel at position p is forwarded exactly when hoff <= p < hoff + hcnt. A count of 0 forwards nothing.
- R3: Lines are numbered from 0 after the frame-start edge. A line closes at the first rising edge of `hsync` or `vsync` after at least one pixel of that line. Only lines L with voff <= L < voff + vcnt are forwarded.
- R4: A forwarded sample appears on `out_data` with `out_valid` high exactly one clock after the edge that sampled it.
- R5: When line voff + vcnt - 1 closes (vcnt > 0), `frame_done` is high for exactly one clock, on the clock after the closing edge. No further data is forwarded until the next frame start.
- R6: If `vsync` rises while the block is still capturing before the last window line has closed (this includes vcnt = 0), capture ends and `frame_done` pulses on the next clock.
- R7: `frame_irq` equals `frame_done` when `irq_en` was high on the edge of the terminating event. Otherwise `frame_irq` stays low.
- R8: Capture begins only at the first falling edge of `vsync` seen after `enable` has been high for a clock. A frame already in progress when `enable` rises yields no data and no `frame_done`.
- R9: The window inputs are sampled at the frame-start edge. Changing them during a frame has no effect until the next frame start.
- R10: Simultaneous edges are handled. A `vsync` fall together with an `hsync` rise starts a frame normally. A `vsync` rise together with an `hsync` rise closes the last line once and produces a single `frame_done` pulse.
- R11: Dropping `enable` stops capture at once. No later sample of that frame is forwarded and no `frame_done` is produced for it.
- R12: While `rst_n` is low, `out_valid`, `frame_done` and `frame_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Capture enable; low returns the block to idle |
| irq_en | input | 1 | Gates `frame_irq` |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| pix_data | input | DATA_W | Camera data byte |
| cfg_hoff | input | CNT_W | Pixels skipped at the start of each line |
| cfg_hcnt | input | CNT_W | Pixels forwarded per window line |
| cfg_voff | input | CNT_W | First window line |
| cfg_vcnt | input | CNT_W | Number of window lines |
| out_valid | output | 1 | Strobe for `out_data` |
| out_data | output | DATA_W | Forwarded pixel byte |
| frame_done | output | 1 | One-cycle end-of-capture pulse |
| frame_irq | output | 1 | End-of-capture pulse gated by `irq_en` |

## Verification
Every result is due one pixel clock after the edge that causes it. A forwarded pixel appears on the clock after it is sampled. The end-of-capture pulses appear on the clock after the closing sync edge. The bench drives each input on a falling clock edge and records what that input should produce. It checks that expectation at the next falling edge, before driving again, so every output is compared in exactly the cycle its single register updates. Expected bytes and pulse positions come from the window arithmetic on the bench's own line and pixel loop indices.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2
  } cwc_state_e;
endpackage

// File: rtl/cwc_sync_edges.sv
module cwc_sync_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic vsync,
  output logic h_rise,
  output logic v_rise,
  output logic v_fall,
  output logic active
);
  logic h_q, v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= 1'b0;
      v_q <= 1'b0;
    end else begin
      h_q <= hsync;
      v_q <= vsync;
    end
  end

  assign h_rise = hsync & ~h_q;
  assign v_rise = vsync & ~v_q;
  assign v_fall = ~vsync & v_q;
  assign active = ~hsync & ~vsync;
endmodule

// File: rtl/cwc_pos_cnt.sv
module cwc_pos_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             active,
  input  logic             blank,
  input  logic             close_evt,
  output logic [CNT_W-1:0] px,
  output logic [CNT_W-1:0] ln,
  output logic             line_end
);
  // a line only closes when it has carried at least one pixel
  assign line_end = close_evt & (px != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px <= '0;
    end else if (frame_start || blank) begin
      px <= '0;
    end else if (active) begin
      px <= px + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ln <= '0;
    end else if (frame_start) begin
      ln <= '0;
    end else if (line_end) begin
      ln <= ln + 1'b1;
    end
  end
endmodule

// File: rtl/cwc_win_gate.sv
module cwc_win_gate #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] px,
  input  logic [CNT_W-1:0] ln,
  input  logic [CNT_W-1:0] hoff,
  input  logic [CNT_W-1:0] hcnt,
  input  logic [CNT_W-1:0] voff,
  input  logic [CNT_W-1:0] vcnt,
  output logic             in_window,
  output logic             on_last_line
);
  localparam int EXT_W = CNT_W + 1;

  // idx lies in [off, off+cnt), computed one bit wider so the end cannot wrap
  function automatic logic span_hit(input logic [CNT_W-1:0] idx,
                                    input logic [CNT_W-1:0] off,
                                    input logic [CNT_W-1:0] cnt);
    logic [EXT_W-1:0] stop;
    stop = {1'b0, off} + {1'b0, cnt};
    return (idx >= off) && ({1'b0, idx} < stop);
  endfunction

  // line idx is the final line of a non-empty span
  function automatic logic span_last(input logic [CNT_W-1:0] idx,
                                     input logic [CNT_W-1:0] off,
                                     input logic [CNT_W-1:0] cnt);
    return (cnt != '0) &&
           (({1'b0, idx} + EXT_W'(1)) == ({1'b0, off} + {1'b0, cnt}));
  endfunction

  assign in_window    = span_hit(px, hoff, hcnt) && span_hit(ln, voff, vcnt);
  assign on_last_line = span_last(ln, voff, vcnt);
endmodule

// File: rtl/cwc_fsm.sv
module cwc_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic v_fall,
  input  logic v_rise,
  input  logic line_end,
  input  logic on_last_line,
  output logic frame_start,
  output logic capturing,
  output logic done_evt
);
  import cwc_pkg::*;

  cwc_state_e state_q, state_d;
  logic last_close, early_close;

  assign frame_start = enable && (state_q == ST_ARMED) && v_fall;
  assign capturing   = enable && (state_q == ST_CAPT);
  assign last_close  = capturing && line_end && on_last_line;
  assign early_close = capturing && v_rise && !last_close;
  assign done_evt    = last_close || early_close;

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_ARMED;
        ST_ARMED: if (v_fall) state_d = ST_CAPT;
        ST_CAPT:  if (done_evt) state_d = ST_ARMED;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/cam_window_crop.sv
module cam_window_crop #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              irq_en,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [DATA_W-1:0] pix_data,
  input  logic [CNT_W-1:0]  cfg_hoff,
  input  logic [CNT_W-1:0]  cfg_hcnt,
  input  logic [CNT_W-1:0]  cfg_voff,
  input  logic [CNT_W-1:0]  cfg_vcnt,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              frame_done,
  output logic              frame_irq
);
  // named internal events, also observed by the bound checker
  logic h_rise, v_rise, v_fall, active;
  logic frame_start, capturing, done_evt;
  logic line_end, in_window, on_last_line, emit;
  logic [CNT_W-1:0] px, ln;
  logic [CNT_W-1:0] win_hoff, win_hcnt, win_voff, win_vcnt;

  cwc_sync_edges edges_i (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .h_rise(h_rise), .v_rise(v_rise), .v_fall(v_fall), .active(active)
  );

  cwc_pos_cnt #(.CNT_W(CNT_W)) pos_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .active(active),
    .blank(hsync | vsync), .close_evt(h_rise | v_rise),
    .px(px), .ln(ln), .line_end(line_end)
  );

  cwc_win_gate #(.CNT_W(CNT_W)) gate_i (
    .px(px), .ln(ln), .hoff(win_hoff), .hcnt(win_hcnt),
    .voff(win_voff), .vcnt(win_vcnt),
    .in_window(in_window), .on_last_line(on_last_line)
  );

  cwc_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .v_fall(v_fall),
    .v_rise(v_rise), .line_end(line_end), .on_last_line(on_last_line),
    .frame_start(frame_start), .capturing(capturing), .done_evt(done_evt)
  );

  // window settings are frozen for the whole frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_hoff <= '0;
      win_hcnt <= '0;
      win_voff <= '0;
      win_vcnt <= '0;
    end else if (frame_start) begin
      win_hoff <= cfg_hoff;
      win_hcnt <= cfg_hcnt;
      win_voff <= cfg_voff;
      win_vcnt <= cfg_vcnt;
    end
  end

  assign emit = capturing && active && in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      frame_done <= 1'b0;
      frame_irq  <= 1'b0;
    end else begin
      out_valid  <= emit;
      if (emit) out_data <= pix_data;
      frame_done <= done_evt;
      frame_irq  <= done_evt && irq_en;
    end
  end
endmodule

// File: rtl/cwc_checker.sv
module cwc_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic irq_en,
  input logic hsync,
  input logic vsync,
  input logic out_valid,
  input logic frame_done,
  input logic frame_irq,
  input logic line_end,
  input logic v_rise,
  input logic frame_start,
  input logic capturing
);
  // R1: forwarded bytes only come from samples with both syncs low
  p_valid_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!hsync && !vsync));

  // R11: nothing is forwarded from a sample taken while disabled
  p_valid_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(enable));

  // R7: interrupt only alongside the done pulse and with the gate set
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> (frame_done && $past(irq_en)));

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R6: done follows either a line close or a vsync rise
  p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(line_end || v_rise));

  // R8: capture begins only through a frame-start edge
  p_start_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capturing) |-> $past(frame_start));
endmodule

bind cam_window_crop cwc_checker chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .irq_en(irq_en),
  .hsync(hsync), .vsync(vsync), .out_valid(out_valid),
  .frame_done(frame_done), .frame_irq(frame_irq), .line_end(line_end),
  .v_rise(v_rise), .frame_start(frame_start), .capturing(capturing)
);

// File: tb/cam_window_crop_tb.sv
module cam_window_crop_tb_top;
  localparam int W  = 6;   // pixels per line
  localparam int H  = 4;   // lines per frame
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, irq_en = 1'b1;
  logic hsync = 1'b0, vsync = 1'b1;
  logic [7:0] pix_data = '0;
  logic [CW-1:0] cfg_hoff = '0, cfg_hcnt = '0, cfg_voff = '0, cfg_vcnt = '0;
  logic out_valid, frame_done, frame_irq;
  logic [7:0] out_data;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  string cur_req = "";
  logic en_want = 1'b0;
  logic pend_v = 1'b0, pend_done = 1'b0, pend_irq = 1'b0;
  logic [7:0] pend_d = '0;

  always #2 clk = ~clk;  // 250 MHz

  cam_window_crop #(.DATA_W(8), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .irq_en(irq_en),
    .hsync(hsync), .vsync(vsync), .pix_data(pix_data),
    .cfg_hoff(cfg_hoff), .cfg_hcnt(cfg_hcnt), .cfg_voff(cfg_voff),
    .cfg_vcnt(cfg_vcnt), .out_valid(out_valid), .out_data(out_data),
    .frame_done(frame_done), .frame_irq(frame_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, cur_req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // one pixel clock: check the previous cycle's results, then drive the next
  task automatic step(input logic h, input logic v, input logic [7:0] d,
                      input logic ev, input logic de);
    @(negedge clk);
    chk("R1/R2/R3/R4 valid", int'(out_valid), int'(pend_v));
    if (pend_v) chk("R4 data", int'(out_data), int'(pend_d));
    chk("R5/R6/R10 done", int'(frame_done), int'(pend_done));
    chk("R7 irq", int'(frame_irq), int'(pend_irq));
    enable = en_want;
    hsync = h; vsync = v; pix_data = d;
    pend_v = ev; pend_d = d; pend_done = de; pend_irq = de && irq_en;
  endtask

  // mode 0: captured; 1: enable rises mid-frame; 2: enable drops at line 1
  task automatic run_frame(input int hoff, input int hcnt, input int voff,
                           input int vcnt, input int mode, input bit sim,
                           input bit cfg_chg, input int fid);
    int lc;
    bit cap, fin;
    cfg_hoff = CW'(hoff); cfg_hcnt = CW'(hcnt);
    cfg_voff = CW'(voff); cfg_vcnt = CW'(vcnt);
    lc  = (vcnt == 0 || voff + vcnt - 1 > H - 1) ? H - 1 : voff + vcnt - 1;
    cap = (mode != 1);
    fin = (mode == 0);
    for (int k = 0; k < H; k++) begin
      for (int c = 0; c < 2; c++) begin
        if (k == 1 && c == 0 && mode == 2) en_want = 1'b0;
        if (k == 1 && c == 0 && mode == 1) en_want = 1'b1;
        step(1'b1, 1'b0, 8'h00, 1'b0, fin && c == 0 && k > 0 && (k - 1) == lc);
        if (k == 1 && c == 0 && cfg_chg) begin  // R9: ignored until next frame
          cfg_hoff = '0; cfg_hcnt = CW'(W); cfg_voff = '0; cfg_vcnt = CW'(H);
        end
      end
      for (int p = 0; p < W; p++) begin
        logic ev;
        ev = cap && !(mode == 2 && k >= 1) && k >= voff && k < voff + vcnt &&
             p >= hoff && p < hoff + hcnt;
        step(1'b0, 1'b0, 8'(k * 16 + p + fid * 7), ev, 1'b0);
      end
    end
    for (int i = 0; i < 3; i++) begin
      if (mode == 2 && i == 1) en_want = 1'b1;
      step(sim ? (i == 0) : (i == 2), 1'b1, 8'h00, 1'b0,
           fin && i == 0 && lc == H - 1);
    end
  endtask

  initial begin
    int fid;
    fid = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    cur_req = "R12";
    chk("R12 valid", int'(out_valid), 0);
    chk("R12 done", int'(frame_done), 0);
    chk("R12 irq", int'(frame_irq), 0);
    rst_n = 1'b1;
    en_want = 1'b1;
    repeat (3) step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0);

    // sweep of window shapes: R2 R3 R4 R5 R6 R7 R10
    cur_req = "sweep";
    for (int ho = 0; ho < 4; ho++)
      for (int hc = 0; hc < 5; hc++)
        for (int vo = 0; vo < 3; vo++)
          for (int vc = 0; vc < 5; vc++) begin
            run_frame(ho, hc, vo, vc, 0, fid[0], 1'b0, fid);
            fid++;
          end

    // R9: mid-frame window change
    cur_req = "R9";
    run_frame(2, 2, 1, 2, 0, 1'b1, 1'b1, fid); fid++;
    run_frame(1, 3, 0, 1, 0, 1'b0, 1'b0, fid); fid++;

    // R7: interrupt gated off
    cur_req = "R7";
    irq_en = 1'b0;
    run_frame(0, 3, 0, 2, 0, 1'b1, 1'b0, fid); fid++;
    run_frame(0, 3, 2, 5, 0, 1'b0, 1'b0, fid); fid++;
    irq_en = 1'b1;

    // R8: enable rising mid-frame leaves that frame alone
    cur_req = "R8";
    en_want = 1'b0;
    step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
    run_frame(0, 6, 0, 4, 1, 1'b1, 1'b0, fid); fid++;
    run_frame(1, 4, 1, 2, 0, 1'b1, 1'b0, fid); fid++;

    // R11: enable dropped during line 1
    cur_req = "R11";
    run_frame(0, 6, 0, 4, 2, 1'b0, 1'b0, fid); fid++;
    run_frame(3, 3, 3, 1, 0, 1'b1, 1'b0, fid); fid++;

    step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
    step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
    summary();
  end

  initial begin
    #(4 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end
endmodule